// File: doc/BRIEF.md
# SD Partial-Sector Window DMA

This block pulls one 512-byte data block from an SD card over the 4-bit data bus and forwards only a selected byte window of it to one of four target memories. The host controller handles commands, responses and the data start bit. It then writes a 32-bit window parameter word and issues a start command. From that point the engine gates the card clock nibble by nibble. It assembles bytes and tracks the byte position inside the sector. Bytes outside the window are discarded. Bytes inside it are written to the selected target with an address that counts up from zero.

Two mode flags let a sector be read in several separate pieces. The start flag tells the engine that the card already sits at the start offset, so forwarding begins with the first byte clocked. Without it, the engine starts counting at sector byte 0 and skips ahead. The end flag makes the engine stop gating the card clock at the end offset, which leaves the card mid-sector for a later resumed transfer. Without it, the engine drains the rest of the sector and its CRC and end bit.

Top module: `sd_window_dma`

## Requirements
- R1: While reset is asserted, and after it is released, `busy_o`, `card_clk_en_o` and `tgt_we_o` are 0. Reset is asynchronous and acts at once, even mid-transfer.
- R2: Each cycle with `card_clk_en_o` high consumes one nibble from `card_dat_i`. Two consecutive data nibbles form one byte, with the high nibble first.
- R3: A start command with `go_data[2]`=0 forwards all 512 bytes, whatever the parameter word holds. The engine then gives 17 further clock enables (16 CRC nibbles and the end bit), discards them and goes idle. This is 1041 enabled cycles in total.
- R4: In the parameter word, bits 31:28 are the start mode and bits 27:16 the start offset. A start mode other than 8 means the engine begins at sector byte 0 and discards bytes below the start offset.
- R5: A start mode of 8 means the card is taken to be at the start offset. The byte position is loaded with it, and forwarding begins with the first byte clocked.
- R6: In the parameter word, bits 15:12 are the end mode and bits 11:0 the end offset. With an end mode other than 8, bytes from the end offset up to byte 511 are discarded, then the 17 tail clocks are given.
- R7: With an end mode of 8 and an end offset below 512, no further clock enable is given once the position reaches the end offset. The card keeps its place, and a later start-mode-8 transfer resumes there.
- R8: An end offset of 512 with end mode 8 behaves like end mode 0: the sector and tail are drained.
- R9: Each forwarded byte gives a one-cycle `tgt_we_o` pulse. `tgt_sel_o` equals `go_data[1:0]` of the accepted start. `tgt_addr_o` is 0 for the first byte after each accepted start and rises by one per byte.
- R10: `busy_o` is 1 from the cycle after an accepted start until the transfer ends. A start command while busy is ignored. A parameter write during a transfer does not change that transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prm_wr | input | 1 | Write strobe for the window parameter word |
| prm_data | input | 32 | Parameter word: start mode, start offset, end mode, end offset |
| go_wr | input | 1 | Start command strobe |
| go_data | input | 3 | Bit 2 partial enable, bits 1:0 target select |
| busy_o | output | 1 | Transfer in progress |
| card_clk_en_o | output | 1 | Card clock gate; one nibble consumed per high cycle |
| card_dat_i | input | 4 | Data nibble presented by the card |
| tgt_we_o | output | 1 | Target write strobe, one cycle per byte |
| tgt_sel_o | output | 2 | Target select of the running transfer |
| tgt_addr_o | output | ADDR_W | Target write address |
| tgt_data_o | output | 8 | Target write data |

## Verification
If the byte position drifts by even one byte, the first forwarded byte already carries the wrong pattern value. The bench checks the data of every write against a position-dependent pattern, so the fault shows within two cycles of the window opening. A wrong stop decision or a miscounted tail changes the total number of clock enables by at least one, and the bench counts that for every transfer. A lost resume position, for example a reload to zero instead of the start offset, is caught when the following chained transfer returns data from the wrong sector bytes.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  // width of the offsets carried by the parameter word
  localparam int OFS_W = 12;
  // mode field value that turns a flag on
  localparam logic [3:0] MODE_ON = 4'h8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_TAIL = 2'd2
  } sdp_state_e;

  typedef struct packed {
    logic [3:0]       smode;
    logic [OFS_W-1:0] start;
    logic [3:0]       emode;
    logic [OFS_W-1:0] stop;
  } prm_t;
endpackage

// File: rtl/sdp_cfg.sv
module sdp_cfg
  import sdp_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int POS_W        = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prm_wr,
  input  logic [31:0]      prm_data,
  input  logic             accept,
  input  logic             go_part,
  input  logic [1:0]       go_sel,
  output logic [POS_W-1:0] load_pos,
  output logic [OFS_W-1:0] win_lo,
  output logic [OFS_W-1:0] win_hi,
  output logic             stop_mid,
  output logic [1:0]       tgt_sel
);
  localparam logic [OFS_W-1:0] LIM = OFS_W'(SECTOR_BYTES);

  prm_t             sh_q, sh_d;
  logic [OFS_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic             stop_q, stop_d;
  logic [1:0]       sel_q, sel_d;
  logic [OFS_W-1:0] start_c, end_c;

  // shadow parameter word, written by the host at any time
  always_comb begin
    sh_d = sh_q;
    if (prm_wr) sh_d = prm_t'(prm_data);
  end

  // offsets beyond the sector are clamped to the sector size
  always_comb begin
    start_c  = (sh_q.start > LIM) ? LIM : sh_q.start;
    end_c    = (sh_q.stop  > LIM) ? LIM : sh_q.stop;
    load_pos = '0;
    if (go_part && (sh_q.smode == MODE_ON)) load_pos = POS_W'(start_c);
  end

  // working copy, frozen at an accepted start
  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    stop_d = stop_q;
    sel_d  = sel_q;
    if (accept) begin
      sel_d = go_sel;
      if (go_part) begin
        lo_d   = start_c;
        hi_d   = end_c;
        stop_d = (sh_q.emode == MODE_ON) && (end_c < LIM);
      end else begin
        lo_d   = '0;
        hi_d   = LIM;
        stop_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      stop_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      sh_q   <= sh_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      stop_q <= stop_d;
      sel_q  <= sel_d;
    end
  end

  assign win_lo   = lo_q;
  assign win_hi   = hi_q;
  assign stop_mid = stop_q;
  assign tgt_sel  = sel_q;
endmodule

// File: rtl/sdp_byte.sv
module sdp_byte #(
  parameter int POS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [POS_W-1:0] load_pos,
  input  logic             data_en,
  input  logic [3:0]       dat,
  output logic [POS_W-1:0] pos,
  output logic             byte_done,
  output logic [7:0]       byte_val
);
  logic             ph_q, ph_d;
  logic [3:0]       hi_q, hi_d;
  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    ph_d  = ph_q;
    hi_d  = hi_q;
    pos_d = pos_q;
    if (accept) begin
      ph_d  = 1'b0;
      pos_d = load_pos;
    end else if (data_en) begin
      ph_d = ~ph_q;
      if (!ph_q) hi_d  = dat;
      else       pos_d = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      hi_q  <= '0;
      pos_q <= '0;
    end else begin
      ph_q  <= ph_d;
      hi_q  <= hi_d;
      pos_q <= pos_d;
    end
  end

  assign pos       = pos_q;
  assign byte_done = data_en & ph_q;
  assign byte_val  = {hi_q, dat};
endmodule

// File: rtl/sdp_ctl.sv
module sdp_ctl
  import sdp_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int POS_W        = 10,
  parameter int CRC_CLKS     = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             stop_mid,
  input  logic [OFS_W-1:0] win_hi,
  input  logic [POS_W-1:0] pos,
  input  logic             byte_done,
  output logic             busy,
  output logic             card_en,
  output logic             data_en
);
  localparam int CRC_W = $clog2(CRC_CLKS);
  localparam logic [CRC_W-1:0] TAIL_LAST = CRC_W'(CRC_CLKS - 1);
  localparam logic [POS_W-1:0] POS_LAST  = POS_W'(SECTOR_BYTES - 1);

  sdp_state_e       st_q, st_d;
  logic [CRC_W-1:0] cnt_q, cnt_d;
  logic             at_stop;

  assign at_stop = stop_mid && (OFS_W'(pos) >= win_hi);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    card_en = 1'b0;
    data_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) st_d = ST_DATA;
      end
      ST_DATA: begin
        if (at_stop) begin
          st_d = ST_IDLE;
        end else begin
          card_en = 1'b1;
          data_en = 1'b1;
          if (byte_done && (pos == POS_LAST)) begin
            st_d  = ST_TAIL;
            cnt_d = '0;
          end
        end
      end
      ST_TAIL: begin
        card_en = 1'b1;
        if (cnt_q == TAIL_LAST) st_d = ST_IDLE;
        else                    cnt_d = cnt_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/sdp_wr.sv
module sdp_wr
  import sdp_pkg::*;
#(
  parameter int POS_W  = 10,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              byte_done,
  input  logic [7:0]        byte_val,
  input  logic [POS_W-1:0]  pos,
  input  logic [OFS_W-1:0]  win_lo,
  input  logic [OFS_W-1:0]  win_hi,
  output logic              tgt_we,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [7:0]        tgt_data
);
  logic              inw, fwd;
  logic [ADDR_W-1:0] cnt_q, cnt_d, addr_q, addr_d;
  logic [7:0]        data_q, data_d;
  logic              we_q, we_d;

  assign inw = (OFS_W'(pos) >= win_lo) && (OFS_W'(pos) < win_hi);
  assign fwd = byte_done & inw;

  always_comb begin
    cnt_d  = cnt_q;
    addr_d = addr_q;
    data_d = data_q;
    we_d   = 1'b0;
    if (accept) begin
      cnt_d = '0;
    end else if (fwd) begin
      we_d   = 1'b1;
      addr_d = cnt_q;
      data_d = byte_val;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      we_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      data_q <= data_d;
      we_q   <= we_d;
    end
  end

  assign tgt_we   = we_q;
  assign tgt_addr = addr_q;
  assign tgt_data = data_q;
endmodule

// File: rtl/sd_window_dma.sv
module sd_window_dma
  import sdp_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int ADDR_W       = 9,
  parameter int CRC_CLKS     = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prm_wr,
  input  logic [31:0]       prm_data,
  input  logic              go_wr,
  input  logic [2:0]        go_data,
  output logic              busy_o,
  output logic              card_clk_en_o,
  input  logic [3:0]        card_dat_i,
  output logic              tgt_we_o,
  output logic [1:0]        tgt_sel_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic [7:0]        tgt_data_o
);
  localparam int POS_W = $clog2(SECTOR_BYTES) + 1;

  logic [1:0]       rs_q;
  logic             rst_s_n;
  logic             busy, accept;
  logic [POS_W-1:0] load_pos, pos;
  logic [OFS_W-1:0] win_lo, win_hi;
  logic             stop_mid, data_en, byte_done;
  logic [7:0]       byte_val;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  assign accept = go_wr & ~busy;

  sdp_cfg #(.SECTOR_BYTES(SECTOR_BYTES), .POS_W(POS_W)) u_cfg (
    .clk(clk), .rst_n(rst_s_n), .prm_wr(prm_wr), .prm_data(prm_data),
    .accept(accept), .go_part(go_data[2]), .go_sel(go_data[1:0]),
    .load_pos(load_pos), .win_lo(win_lo), .win_hi(win_hi),
    .stop_mid(stop_mid), .tgt_sel(tgt_sel_o)
  );

  sdp_ctl #(.SECTOR_BYTES(SECTOR_BYTES), .POS_W(POS_W), .CRC_CLKS(CRC_CLKS)) u_ctl (
    .clk(clk), .rst_n(rst_s_n), .accept(accept), .stop_mid(stop_mid),
    .win_hi(win_hi), .pos(pos), .byte_done(byte_done),
    .busy(busy), .card_en(card_clk_en_o), .data_en(data_en)
  );

  sdp_byte #(.POS_W(POS_W)) u_byte (
    .clk(clk), .rst_n(rst_s_n), .accept(accept), .load_pos(load_pos),
    .data_en(data_en), .dat(card_dat_i), .pos(pos),
    .byte_done(byte_done), .byte_val(byte_val)
  );

  sdp_wr #(.POS_W(POS_W), .ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_s_n), .accept(accept), .byte_done(byte_done),
    .byte_val(byte_val), .pos(pos), .win_lo(win_lo), .win_hi(win_hi),
    .tgt_we(tgt_we_o), .tgt_addr(tgt_addr_o), .tgt_data(tgt_data_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/sdp_chk.sv
module sdp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       go_wr,
  input logic       busy,
  input logic       card_en,
  input logic       tgt_we,
  input logic [1:0] tgt_sel
);
  // R2
  card_en_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_en |-> busy);

  // R9
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_we |=> !tgt_we);

  // R9
  we_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_we |-> $past(busy));

  // R10
  go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && !busy) |=> busy);

  // R10
  go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && busy) |=> $stable(tgt_sel));
endmodule

bind sd_window_dma sdp_chk u_sdp_chk (
  .clk(clk), .rst_n(rst_s_n), .go_wr(go_wr), .busy(busy_o),
  .card_en(card_clk_en_o), .tgt_we(tgt_we_o), .tgt_sel(tgt_sel_o)
);

// File: tb/test_sd_window_dma.sv
module test_sd_window_dma;
  localparam int ADDR_W = 9;

  typedef struct packed {
    logic        rw;   // restart card at sector byte 0
    logic        pa;
    logic [1:0]  ts;
    logic [3:0]  sm;
    logic [11:0] st;
    logic [3:0]  em;
    logic [11:0] en;
    logic [9:0]  n;    // expected forwarded bytes
    logic [10:0] nib;  // expected clock enables
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 2'd1, 4'h0, 12'd0,   4'h0, 12'd0,   10'd512, 11'd1041},
    '{1'b1, 1'b1, 2'd0, 4'h0, 12'd16,  4'h0, 12'd512, 10'd496, 11'd1041},
    '{1'b1, 1'b1, 2'd2, 4'h0, 12'd100, 4'h0, 12'd200, 10'd100, 11'd1041},
    '{1'b1, 1'b1, 2'd3, 4'h0, 12'd0,   4'h8, 12'd64,  10'd64,  11'd128},
    '{1'b0, 1'b1, 2'd3, 4'h8, 12'd64,  4'h8, 12'd128, 10'd64,  11'd128},
    '{1'b0, 1'b1, 2'd1, 4'h8, 12'd128, 4'h0, 12'd512, 10'd384, 11'd785},
    '{1'b1, 1'b1, 2'd2, 4'h0, 12'd500, 4'h8, 12'd512, 10'd12,  11'd1041},
    '{1'b1, 1'b0, 2'd0, 4'h8, 12'd300, 4'h8, 12'd310, 10'd512, 11'd1041},
    '{1'b1, 1'b1, 2'd1, 4'h0, 12'd40,  4'h8, 12'd40,  10'd0,   11'd80},
    '{1'b0, 1'b1, 2'd1, 4'h8, 12'd40,  4'h8, 12'd41,  10'd1,   11'd2},
    '{1'b0, 1'b1, 2'd0, 4'h8, 12'd41,  4'h0, 12'd512, 10'd471, 11'd959}
  };

  logic              clk;
  logic              rst_n;
  logic              prm_wr;
  logic [31:0]       prm_data;
  logic              go_wr;
  logic [2:0]        go_data;
  logic              busy;
  logic              card_en;
  logic [3:0]        card_dat;
  logic              tgt_we;
  logic [1:0]        tgt_sel;
  logic [ADDR_W-1:0] tgt_addr;
  logic [7:0]        tgt_data;

  int checks = 0;
  int errors = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  sd_window_dma #(.ADDR_W(ADDR_W)) i_sd_window_dma (
    .clk(clk), .rst_n(rst_n), .prm_wr(prm_wr), .prm_data(prm_data),
    .go_wr(go_wr), .go_data(go_data), .busy_o(busy),
    .card_clk_en_o(card_en), .card_dat_i(card_dat), .tgt_we_o(tgt_we),
    .tgt_sel_o(tgt_sel), .tgt_addr_o(tgt_addr), .tgt_data_o(tgt_data)
  );

  // card model: sector byte pattern, then constant tail nibbles
  function automatic logic [7:0] pat(int q);
    return 8'((q * 37) + ((q >> 8) * 11) + 5);
  endfunction

  function automatic logic [3:0] nib_at(int n);
    logic [7:0] b;
    if (n >= 1024) return 4'hA;
    b = pat(n >> 1);
    return n[0] ? b[3:0] : b[7:4];
  endfunction

  int   nib_idx = 0;
  int   nib_cnt = 0;
  logic rewind  = 1'b0;
  logic cnt_clr = 1'b0;
  assign card_dat = nib_at(nib_idx);

  always @(posedge clk) begin
    if (rewind)       nib_idx <= 0;
    else if (card_en) nib_idx <= nib_idx + 1;
    if (cnt_clr)      nib_cnt <= 0;
    else if (card_en) nib_cnt <= nib_cnt + 1;
  end

  // write capture, away from the active edge
  logic [7:0]        cap_d [512];
  logic [ADDR_W-1:0] cap_a [512];
  logic [1:0]        cap_s [512];
  int   cap_n   = 0;
  logic cap_clr = 1'b0;

  always @(negedge clk) begin
    if (cap_clr) cap_n <= 0;
    else if (tgt_we) begin
      if (cap_n < 512) begin
        cap_d[cap_n] <= tgt_data;
        cap_a[cap_n] <= tgt_addr;
        cap_s[cap_n] <= tgt_sel;
      end
      cap_n <= cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic clear_mon(input logic rw);
    @(negedge clk); rewind = rw; cnt_clr = 1'b1;
    @(negedge clk); rewind = 1'b0; cnt_clr = 1'b0;
    @(posedge clk); cap_clr = 1'b1;
    @(posedge clk); cap_clr = 1'b0;
  endtask

  task automatic issue(input logic [31:0] pw, input logic [2:0] gd);
    @(negedge clk); prm_wr = 1'b1; prm_data = pw;
    @(negedge clk); prm_wr = 1'b0; go_wr = 1'b1; go_data = gd;
    @(negedge clk); go_wr = 1'b0;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_xfer(input int first, input int n, input int nib,
                            input logic [1:0] ts, input string tag);
    int bad_d, bad_a, bad_s, k0;
    bad_d = 0; bad_a = 0; bad_s = 0; k0 = -1;
    chk(busy == 1'b0, "R10", "busy after end", int'(busy), 0);
    chk(cap_n == n, tag, "forwarded byte count", cap_n, n);
    chk(nib_cnt == nib, tag, "card clock enables", nib_cnt, nib);
    for (int k = 0; k < cap_n && k < 512; k++) begin
      if (cap_d[k] !== pat(first + k)) begin
        if (k0 < 0) k0 = k;
        bad_d++;
      end
      if (cap_a[k] !== ADDR_W'(k)) bad_a++;
      if (cap_s[k] !== ts) bad_s++;
    end
    chk(bad_d == 0, {"R2 ", tag}, "data mismatches",
        bad_d, 0);
    if (k0 >= 0)
      $display("  first bad byte %0d got %0d expected %0d", k0,
               cap_d[k0], pat(first + k0));
    chk(bad_a == 0, "R9", "address mismatches", bad_a, 0);
    chk(bad_s == 0, "R9", "select mismatches", bad_s, 0);
  endtask

  function automatic string tag_of(vec_t v);
    string s;
    if (!v.pa) return "R3";
    s = (v.sm == 4'h8) ? "R5" : "R4";
    if (v.en >= 12'd512) s = {s, (v.em == 4'h8) ? " R8" : " R6"};
    else                 s = {s, (v.em == 4'h8) ? " R7" : " R6"};
    return s;
  endfunction

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: got %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; prm_wr = 1'b0; prm_data = '0; go_wr = 1'b0; go_data = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(busy == 0 && card_en == 0 && tgt_we == 0, "R1", "outputs in reset",
        {busy, card_en, tgt_we}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 after release
    chk(busy == 0 && card_en == 0 && tgt_we == 0, "R1", "outputs after reset",
        {busy, card_en, tgt_we}, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      clear_mon(VEC[i].rw);
      issue({VEC[i].sm, VEC[i].st, VEC[i].em, VEC[i].en}, {VEC[i].pa, VEC[i].ts});
      chk(busy == 1'b1, "R10", "busy after start", int'(busy), 1);
      wait_idle();
      check_xfer(VEC[i].pa ? int'(VEC[i].st) : 0, int'(VEC[i].n),
                 int'(VEC[i].nib), VEC[i].ts, tag_of(VEC[i]));
    end

    // R10: start and parameter write while busy are ignored
    clear_mon(1'b1);
    issue(32'h0, 3'b010);
    repeat (300) @(negedge clk);
    prm_wr = 1'b1; prm_data = {4'h8, 12'd5, 4'h8, 12'd9};
    @(negedge clk); prm_wr = 1'b0; go_wr = 1'b1; go_data = 3'b111;
    @(negedge clk); go_wr = 1'b0;
    wait_idle();
    check_xfer(0, 512, 1041, 2'd2, "R10");

    // R1: reset in the middle of a transfer
    clear_mon(1'b1);
    issue(32'h0, 3'b001);
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(busy == 0 && card_en == 0 && tgt_we == 0, "R1", "outputs on mid reset",
        {busy, card_en, tgt_we}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(busy == 0 && card_en == 0, "R1", "idle after mid reset",
        {busy, card_en}, 0);

    // recovery: a full sector after the reset
    clear_mon(1'b1);
    issue(32'h0, 3'b011);
    wait_idle();
    check_xfer(0, 512, 1041, 2'd3, "R3");

    summary();
    $finish;
  end
endmodule